// File: doc/BRIEF.md
# ADC Event Status and Interrupt Register

This block gathers every event that a multi-channel analog-to-digital converter controller reports into a single 32-bit status word. It also turns that word into an interrupt line and a sequence-A request line. For each channel it stores a sticky threshold-event flag. The flag is set by a pulse from the compare logic, either an out-of-range result or a threshold crossing, and only when that kind of event is enabled for the channel. Software clears a stored flag by writing a 1 to its bit.

The overrun levels of the per-channel result registers are passed straight into the word, and so are those of the two sequence data registers; none of these bits is stored here. The sequence-A flag has two behaviours, chosen by a mode input:
- With the mode low, the flag is a data-valid bit. It is set at the end of each conversion in sequence A and cleared when the sequence-A data register is read.
- With the mode high, the flag latches once per completed sequence. It is cleared only by a software write of 1.

A read on the register bus returns the whole word in the same cycle. The interrupt and request outputs are registered.

Top module: `adc_event_status`

## Requirements
- R1: Threshold flag bit i (bits 0 to 11) sets on a clock edge when `cmpOutside[i] & enOutside[i]` or `cmpCross[i] & enCross[i]` is high; a pulse whose type is not enabled leaves the bit at 0.
- R2: A set threshold flag stays set until a write with `wrEn` high and a 1 in its bit of `wrData`; writing 0 to the bit leaves it unchanged.
- R3: When a set condition and a write-one-to-clear reach the same stored flag in the same cycle, the flag ends set.
- R4: Bits 12 to 23 of the word equal `chanOvr[0..11]`, bit 24 equals `seqAOvr` and bit 25 equals `seqBOvr`, combinationally and with no storage.
- R5: With `rdEn` high, bits 26, 27 and 29 to 31 read 0 whatever was written; with `rdEn` low, `rdData` is all zeros.
- R6: With `seqMode` = 0, bit 28 is a data-valid bit. `convDone` sets it and `gdatRead` clears it; if both arrive in the same cycle, the bit ends set. Writing 1 to bit 28 has no effect in this mode.
- R7: With `seqMode` = 1, bit 28 sets on `endSeq` and is cleared only by writing 1 to bit 28; `gdatRead` has no effect in this mode.
- R8: `irq` is high one cycle after any of the following holds:
  - a threshold flag is set while at least one of its channel's enables is high;
  - `ovrIntEn` is high and any overrun bit (12 to 25) is high;
  - `seqIntEn` is high and bit 28 is set.

  `irq` falls one cycle after none of these holds.
- R9: `seqReq` is high one cycle after bit 28 and `seqIntEn` are both high, and falls one cycle after either one drops.
- R10: During and right after reset, the word reads 0 (with no overrun input high) and `irq` and `seqReq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| rdEn | input | 1 | Register read strobe |
| wrEn | input | 1 | Register write strobe (write-one-to-clear) |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Status word, zero when not read |
| cmpOutside | input | 12 | Per-channel out-of-range event pulses |
| cmpCross | input | 12 | Per-channel threshold-crossing event pulses |
| enOutside | input | 12 | Per-channel enable for out-of-range events |
| enCross | input | 12 | Per-channel enable for crossing events |
| ovrIntEn | input | 1 | Interrupt enable for overrun bits |
| seqIntEn | input | 1 | Interrupt/request enable for the sequence-A flag |
| chanOvr | input | 12 | Per-channel result overrun levels |
| seqAOvr | input | 1 | Sequence-A data register overrun level |
| seqBOvr | input | 1 | Sequence-B data register overrun level |
| seqMode | input | 1 | Sequence-A flag mode: 0 data-valid, 1 end of sequence |
| convDone | input | 1 | End-of-conversion strobe within sequence A |
| endSeq | input | 1 | End-of-sequence strobe for sequence A |
| gdatRead | input | 1 | Read strobe of the sequence-A data register |
| irq | output | 1 | Registered interrupt request |
| seqReq | output | 1 | Registered sequence-A interrupt/DMA request |

## Verification
The assertions are checked on every cycle:
- a stored threshold flag never rises without an enabled event;
- a stored flag never falls without a matching clear;
- a set always wins over a same-cycle clear;
- the end-of-sequence flag holds against data-register reads;
- the reserved bits always read as zero.

Some behaviours can only be shown by the bench's scenarios. These are the exact enable-by-event sweep over every channel, the mapping of the overrun levels to their bit positions, and the mode-dependent effect of writes and data-register reads on bit 28. They also include the one-cycle registered latency of `irq` and `seqReq`, both when they rise and when they fall.

// File: rtl/adc_evt_pkg.sv
package adc_evt_pkg;

  // Strobes from control to datapath for the sequence-A flag pair.
  typedef struct packed {
    logic setValid;  // end of a conversion in sequence A
    logic clrValid;  // sequence-A data register read
    logic setDone;   // end of a complete sequence (mode 1 only)
    logic clrDone;   // software write of 1 to the sequence bit (mode 1 only)
  } seqStrobe_t;

endpackage

// File: rtl/adc_evt_ctrl.sv
module adc_evt_ctrl
  import adc_evt_pkg::*;
#(
  parameter int NUM_CH  = 12,
  parameter int WORD_W  = 32,
  parameter int SEQ_BIT = 28
) (
  input  logic              wrEn,
  input  logic [WORD_W-1:0] wrData,
  input  logic              seqMode,
  input  logic              convDone,
  input  logic              endSeq,
  input  logic              gdatRead,
  output logic [NUM_CH-1:0] clrThr,
  output seqStrobe_t        strobes
);

  // Bits between the threshold field and the sequence bit, and above it,
  // carry nothing a write can act on.
  logic unusedWrBits;
  assign unusedWrBits = ^{wrData[WORD_W-1:SEQ_BIT+1], wrData[SEQ_BIT-1:NUM_CH]};

  always_comb begin
    clrThr           = wrEn ? wrData[NUM_CH-1:0] : '0;
    strobes.setValid = convDone;
    strobes.clrValid = gdatRead;
    strobes.setDone  = endSeq & seqMode;
    strobes.clrDone  = wrEn & wrData[SEQ_BIT] & seqMode;
  end

endmodule

// File: rtl/adc_evt_datapath.sv
module adc_evt_datapath
  import adc_evt_pkg::*;
#(
  parameter int NUM_CH  = 12,
  parameter int WORD_W  = 32,
  parameter int SEQ_BIT = 28
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] cmpOutside,
  input  logic [NUM_CH-1:0] cmpCross,
  input  logic [NUM_CH-1:0] enOutside,
  input  logic [NUM_CH-1:0] enCross,
  input  logic [NUM_CH-1:0] clrThr,
  input  seqStrobe_t        strobes,
  input  logic              seqMode,
  input  logic [NUM_CH-1:0] chanOvr,
  input  logic              seqAOvr,
  input  logic              seqBOvr,
  input  logic              ovrIntEn,
  input  logic              seqIntEn,
  output logic [WORD_W-1:0] flagWord,
  output logic              irq,
  output logic              seqReq
);

  localparam int OVR_LSB  = NUM_CH;
  localparam int SEQA_OVR = 2 * NUM_CH;
  localparam int SEQB_OVR = 2 * NUM_CH + 1;

  logic [NUM_CH-1:0] thrFlags;
  logic [NUM_CH-1:0] thrSet;
  logic              seqValid;
  logic              seqDone;
  logic              seqFlag;
  logic              irqNext;

  // One sticky flag per channel; a same-cycle set beats the clear.
  for (genvar i = 0; i < NUM_CH; i++) begin : gChan
    assign thrSet[i] = (cmpOutside[i] & enOutside[i]) | (cmpCross[i] & enCross[i]);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) thrFlags[i] <= 1'b0;
      else       thrFlags[i] <= thrSet[i] | (thrFlags[i] & ~clrThr[i]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seqValid <= 1'b0;
      seqDone  <= 1'b0;
    end else begin
      seqValid <= strobes.setValid | (seqValid & ~strobes.clrValid);
      seqDone  <= strobes.setDone  | (seqDone  & ~strobes.clrDone);
    end
  end

  assign seqFlag = seqMode ? seqDone : seqValid;

  always_comb begin
    flagWord                        = '0;
    flagWord[NUM_CH-1:0]            = thrFlags;
    flagWord[OVR_LSB +: NUM_CH]     = chanOvr;
    flagWord[SEQA_OVR]              = seqAOvr;
    flagWord[SEQB_OVR]              = seqBOvr;
    flagWord[SEQ_BIT]               = seqFlag;
  end

  assign irqNext = (|(thrFlags & (enOutside | enCross)))
                 | (ovrIntEn & ((|chanOvr) | seqAOvr | seqBOvr))
                 | (seqIntEn & seqFlag);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irq    <= 1'b0;
      seqReq <= 1'b0;
    end else begin
      irq    <= irqNext;
      seqReq <= seqIntEn & seqFlag;
    end
  end

  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((thrFlags & ~$past(thrFlags) & ~$past(thrSet)) == '0)); // R1

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(thrFlags) & ~$past(clrThr) & ~thrFlags) == '0)); // R2

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(thrSet) & ~thrFlags) == '0)); // R3

  AST_VALID_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.clrValid && !strobes.setValid) |=> !seqValid); // R6

  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (seqDone && !strobes.clrDone) |=> seqDone); // R7

endmodule

// File: rtl/adc_event_status.sv
module adc_event_status
  import adc_evt_pkg::*;
#(
  parameter int NUM_CH  = 12,
  parameter int WORD_W  = 32,
  parameter int SEQ_BIT = 28
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [WORD_W-1:0] wrData,
  output logic [WORD_W-1:0] rdData,
  input  logic [NUM_CH-1:0] cmpOutside,
  input  logic [NUM_CH-1:0] cmpCross,
  input  logic [NUM_CH-1:0] enOutside,
  input  logic [NUM_CH-1:0] enCross,
  input  logic              ovrIntEn,
  input  logic              seqIntEn,
  input  logic [NUM_CH-1:0] chanOvr,
  input  logic              seqAOvr,
  input  logic              seqBOvr,
  input  logic              seqMode,
  input  logic              convDone,
  input  logic              endSeq,
  input  logic              gdatRead,
  output logic              irq,
  output logic              seqReq
);

  // Field layout needs 2*NUM_CH+2 <= SEQ_BIT < WORD_W.
  localparam int RSV_LSB = 2 * NUM_CH + 2;

  logic [NUM_CH-1:0] clrThr;
  seqStrobe_t        strobes;
  logic [WORD_W-1:0] flagWord;

  adc_evt_ctrl #(.NUM_CH(NUM_CH), .WORD_W(WORD_W), .SEQ_BIT(SEQ_BIT)) uCtrl (
    .wrEn     (wrEn),
    .wrData   (wrData),
    .seqMode  (seqMode),
    .convDone (convDone),
    .endSeq   (endSeq),
    .gdatRead (gdatRead),
    .clrThr   (clrThr),
    .strobes  (strobes)
  );

  adc_evt_datapath #(.NUM_CH(NUM_CH), .WORD_W(WORD_W), .SEQ_BIT(SEQ_BIT)) uData (
    .clk        (clk),
    .rstN       (rstN),
    .cmpOutside (cmpOutside),
    .cmpCross   (cmpCross),
    .enOutside  (enOutside),
    .enCross    (enCross),
    .clrThr     (clrThr),
    .strobes    (strobes),
    .seqMode    (seqMode),
    .chanOvr    (chanOvr),
    .seqAOvr    (seqAOvr),
    .seqBOvr    (seqBOvr),
    .ovrIntEn   (ovrIntEn),
    .seqIntEn   (seqIntEn),
    .flagWord   (flagWord),
    .irq        (irq),
    .seqReq     (seqReq)
  );

  assign rdData = rdEn ? flagWord : '0;

  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |-> ((rdData[WORD_W-1:SEQ_BIT+1] == '0) && (rdData[SEQ_BIT-1:RSV_LSB] == '0))); // R5

endmodule

// File: tb/tb_adc_event_status.sv
module tb_adc_event_status;

  localparam int NCH = 12;

  logic clk = 1'b0;
  logic rstN;
  logic rdEn, wrEn;
  logic [31:0] wrData, rdData;
  logic [NCH-1:0] cmpOutside, cmpCross, enOutside, enCross, chanOvr;
  logic ovrIntEn, seqIntEn, seqAOvr, seqBOvr, seqMode;
  logic convDone, endSeq, gdatRead, irq, seqReq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  adc_event_status dut (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .cmpOutside(cmpOutside), .cmpCross(cmpCross),
    .enOutside(enOutside), .enCross(enCross), .ovrIntEn(ovrIntEn),
    .seqIntEn(seqIntEn), .chanOvr(chanOvr), .seqAOvr(seqAOvr),
    .seqBOvr(seqBOvr), .seqMode(seqMode), .convDone(convDone),
    .endSeq(endSeq), .gdatRead(gdatRead), .irq(irq), .seqReq(seqReq)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic clearPulses();
    cmpOutside = '0; cmpCross = '0; wrEn = 1'b0; wrData = '0;
    convDone = 1'b0; endSeq = 1'b0; gdatRead = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; rdEn = 1'b1; clearPulses();
    enOutside = '0; enCross = '0; chanOvr = '0; seqAOvr = 1'b0; seqBOvr = 1'b0;
    ovrIntEn = 1'b0; seqIntEn = 1'b0; seqMode = 1'b0;
    repeat (3) step();
    chk("R10 word in reset", rdData, 32'h0);
    chk("R10 irq in reset", {31'b0, irq}, 32'h0);
    rstN = 1'b1;
    step();
    chk("R10 word after reset", rdData, 32'h0);
    chk("R10 outputs after reset", {30'b0, irq, seqReq}, 32'h0);

    // R1/R2/R8: sweep every channel over all enable and event combinations
    for (int ch = 0; ch < NCH; ch++) begin
      for (int en = 0; en < 4; en++) begin
        for (int ev = 0; ev < 4; ev++) begin
          logic [31:0] expW;
          enOutside = '0; enCross = '0;
          enOutside[ch] = en[0]; enCross[ch] = en[1];
          cmpOutside[ch] = ev[0]; cmpCross[ch] = ev[1];
          step();
          clearPulses();
          expW = ((ev & en) != 0) ? (32'h1 << ch) : 32'h0;
          chk("R1 threshold set", rdData, expW);
          step();
          chk("R8 irq from threshold flag", {31'b0, irq}, {31'b0, expW != 0});
          wrEn = 1'b1; wrData = 32'h1 << ch;
          step();
          clearPulses();
          chk("R2 write-one clear", rdData, 32'h0);
          step();
          chk("R8 irq falls after clear", {31'b0, irq}, 32'h0);
        end
      end
    end

    // R2: partial clears and write of zero
    enOutside = '1; enCross = '0;
    for (int k = 0; k < 8; k++) begin
      logic [31:0] m;
      cmpOutside = '1;
      step();
      clearPulses();
      wrEn = 1'b1; wrData = 32'h0;
      step();
      clearPulses();
      chk("R2 write of zero keeps flags", rdData, 32'h0000_0FFF);
      m = (32'(k) * 32'h5A3) & 32'hFFF;
      wrEn = 1'b1; wrData = m | 32'hEFFF_F000;
      step();
      clearPulses();
      chk("R2 masked clear", rdData, 32'hFFF & ~m);
      wrEn = 1'b1; wrData = 32'hFFF;
      step();
      clearPulses();
    end

    // R3: set and clear in the same cycle
    for (int ch = 0; ch < NCH; ch++) begin
      cmpOutside[ch] = 1'b1; wrEn = 1'b1; wrData = 32'h1 << ch;
      step();
      clearPulses();
      chk("R3 set wins over clear", rdData, 32'h1 << ch);
      wrEn = 1'b1; wrData = 32'h1 << ch;
      step();
      clearPulses();
    end
    enOutside = '0;
    step();

    // R4/R8: overrun bits are live mirrors
    ovrIntEn = 1'b1;
    for (int i = 0; i < 14; i++) begin
      logic [13:0] v;
      v = 14'h1 << i;
      chanOvr = v[11:0]; seqAOvr = v[12]; seqBOvr = v[13];
      #1;
      chk("R4 overrun mirror", rdData, {18'b0, v} << 12);
      step();
      chk("R8 irq from overrun", {31'b0, irq}, 32'h1);
    end
    chanOvr = 12'hA5C; seqAOvr = 1'b1; seqBOvr = 1'b0;
    #1;
    chk("R4 overrun pattern", rdData, 32'h0000_0000 | (32'hA5C << 12) | (32'h1 << 24));
    ovrIntEn = 1'b0;
    step();
    step();
    chk("R8 overrun masked", {31'b0, irq}, 32'h0);

    // R5: reserved and upper bits
    chanOvr = '1; seqAOvr = 1'b1; seqBOvr = 1'b1;
    enOutside = '1; cmpOutside = '1;
    step();
    clearPulses();
    wrEn = 1'b1; wrData = 32'hEC00_0000;
    step();
    clearPulses();
    chk("R5 reserved read zero", rdData, 32'h03FF_FFFF);
    rdEn = 1'b0;
    #1;
    chk("R5 no read gives zero", rdData, 32'h0);
    rdEn = 1'b1;
    wrEn = 1'b1; wrData = 32'hFFF;
    chanOvr = '0; seqAOvr = 1'b0; seqBOvr = 1'b0; enOutside = '0;
    step();
    clearPulses();
    chk("R5 cleared back to zero", rdData, 32'h0);

    // R6: data-valid mode
    seqMode = 1'b0;
    convDone = 1'b1; step(); clearPulses();
    chk("R6 conversion sets bit 28", rdData, 32'h1000_0000);
    wrEn = 1'b1; wrData = 32'h1000_0000; step(); clearPulses();
    chk("R6 write of 1 ignored in mode 0", rdData, 32'h1000_0000);
    gdatRead = 1'b1; step(); clearPulses();
    chk("R6 data read clears", rdData, 32'h0);
    convDone = 1'b1; gdatRead = 1'b1; step(); clearPulses();
    chk("R6 set wins over read", rdData, 32'h1000_0000);

    // R9/R8: request line follows flag and enable
    seqIntEn = 1'b1;
    step();
    chk("R9 request rises", {30'b0, irq, seqReq}, 32'h3);
    gdatRead = 1'b1; step(); clearPulses();
    chk("R9 request still high on clear edge", {31'b0, seqReq}, 32'h1);
    step();
    chk("R9 request falls", {30'b0, irq, seqReq}, 32'h0);
    seqIntEn = 1'b0;

    // R7: end-of-sequence mode
    seqMode = 1'b1;
    endSeq = 1'b1; step(); clearPulses();
    chk("R7 sequence end sets bit 28", rdData, 32'h1000_0000);
    gdatRead = 1'b1; step(); clearPulses();
    chk("R7 data read ignored in mode 1", rdData, 32'h1000_0000);
    wrEn = 1'b1; wrData = 32'h1000_0000; step(); clearPulses();
    chk("R7 write of 1 clears", rdData, 32'h0);
    endSeq = 1'b1; wrEn = 1'b1; wrData = 32'h1000_0000; step(); clearPulses();
    chk("R7 R3 set wins over write clear", rdData, 32'h1000_0000);
    seqIntEn = 1'b1; step();
    chk("R9 request in mode 1", {31'b0, seqReq}, 32'h1);
    wrEn = 1'b1; wrData = 32'h1000_0000; step(); clearPulses();
    step();
    chk("R9 request falls in mode 1", {30'b0, irq, seqReq}, 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule